// File: doc/BRIEF.md
# In-Order Reorder Buffer

This block is a circular buffer that gives each decoded micro-operation a slot in program order and holds its result until the operation can retire. The slot number is the operation's tag. Renamed operands use the same tag to find their producer. Each slot also stores the architectural register that its commit must write. The slots therefore serve as the physical register space for renaming.

Execution units report results on a write-back port that carries the slot tag. Results may arrive in any order. A consumer can read a finished but uncommitted value through a tag-addressed read port. Retirement happens only at the oldest slot, at most one slot per cycle, and it drives the committed register file. Decode is stalled while the full flag is high. A single flush input discards every slot in flight.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `full`=0, `retValid`=0, `allocTag`=0, and `rdReady`=0 for every tag.
- R2: `allocTag` shows the slot that the next allocation takes. Granted allocations receive consecutive tags 0,1,2,…, which wrap from DEPTH-1 back to 0. `allocGrant` = `allocReq` & !`full` & !`flush`.
- R3: `full` is 1 exactly when DEPTH slots are in flight. While `full` is 1, `allocGrant` is 0 and no slot is taken.
- R4: A write-back with `wbValid`=1 to an occupied slot stores `wbData` and marks the slot finished. From the next cycle on, that tag reads back with `rdReady`=1 and `rdData`=`wbData`.
- R5: A write-back to a slot that is not occupied has no effect. The slot still reads `rdReady`=0, and it stays 0 after the slot is later allocated, until a new write-back arrives.
- R6: `retValid` is 1 only when the oldest slot is occupied and finished. A finished younger slot never retires ahead of an unfinished older one.
- R7: During a retire cycle, `retDest`, `retHasDest` and `retData` carry the oldest slot's destination, destination flag and result. The slot is freed at that clock edge, and at most one slot retires per cycle.
- R8: A slot allocated with `allocHasDest`=0 still retires in order, and it does so with `retHasDest`=0.
- R9: While `flush`=1, `retValid`=0 and nothing is written. After the flush edge the buffer is empty and the next tag is 0.
- R10: An allocation and a retirement in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all slots |
| allocReq | input | 1 | Decode requests a slot |
| allocHasDest | input | 1 | Operation writes a register |
| allocDest | input | AREG_W | Architectural destination |
| allocGrant | output | 1 | Slot granted this cycle |
| allocTag | output | TAG_W | Tag of the next slot |
| full | output | 1 | All slots in flight; stall decode |
| wbValid | input | 1 | Write-back strobe |
| wbTag | input | TAG_W | Write-back slot tag |
| wbData | input | DATA_W | Write-back result |
| rdTag | input | TAG_W | Operand read tag |
| rdReady | output | 1 | Read slot occupied and finished |
| rdData | output | DATA_W | Read slot result |
| retValid | output | 1 | Oldest slot retires this cycle |
| retHasDest | output | 1 | Retiring slot writes a register |
| retDest | output | AREG_W | Register to update |
| retData | output | DATA_W | Value to commit |

## Verification
The allocation grant, the next tag, the full flag and the retire outputs are combinational from the current state and inputs, so they are checked in the same cycle the stimulus is applied. Inputs change on the falling edge and checks follow one time unit later, before the next rising edge. A write-back changes state at the next rising edge, so its result is checked on the read port or the retire port one cycle after the write-back is driven. Freeing a slot and a flush also take effect at the next rising edge, so the full flag, the next tag and the retire outputs are rechecked in the following cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // strobes from control to the storage array
  typedef struct packed {
    logic allocEn;   // capture destination into tail slot
    logic wbEn;      // capture result into tagged slot
  } robStrobe_t;
endpackage

// File: rtl/rob_dpath.sv
module rob_dpath
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int AREG_W = 3,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  robStrobe_t        strobe,
  input  logic [TAG_W-1:0]  tailIdx,
  input  logic [TAG_W-1:0]  headIdx,
  input  logic [AREG_W-1:0] allocDest,
  input  logic [TAG_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbData,
  input  logic [TAG_W-1:0]  rdTag,
  output logic [DATA_W-1:0] rdData,
  output logic [AREG_W-1:0] retDest,
  output logic [DATA_W-1:0] retData
);
  logic [AREG_W-1:0] destQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        destQ[gi] <= '0;
        dataQ[gi] <= '0;
      end else begin
        if (strobe.allocEn && tailIdx == TAG_W'(gi)) destQ[gi] <= allocDest;
        if (strobe.wbEn && wbTag == TAG_W'(gi))      dataQ[gi] <= wbData;
      end
    end
  end

  assign rdData  = dataQ[rdTag];
  assign retDest = destQ[headIdx];
  assign retData = dataQ[headIdx];
endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             allocReq,
  input  logic             allocHasDest,
  input  logic             wbValid,
  input  logic [TAG_W-1:0] wbTag,
  input  logic [TAG_W-1:0] rdTag,
  output logic             allocGrant,
  output logic [TAG_W-1:0] allocTag,
  output logic             full,
  output logic             rdReady,
  output logic             retValid,
  output logic             retHasDest,
  output robStrobe_t       strobe,
  output logic [TAG_W-1:0] headIdx,
  output logic [TAG_W-1:0] tailIdx
);
  logic [DEPTH-1:0] validQ, doneQ, hasDestQ;
  logic [TAG_W-1:0] headQ, tailQ;
  logic [CNT_W-1:0] countQ;
  logic allocFire, retFire, wbAccept;

  assign full      = (countQ == CNT_W'(DEPTH));
  assign allocFire = allocReq && !full && !flush;
  assign retFire   = validQ[headQ] && doneQ[headQ] && !flush;
  assign wbAccept  = wbValid && validQ[wbTag] && !flush;

  assign allocGrant = allocFire;
  assign allocTag   = tailQ;
  assign retValid   = retFire;
  assign retHasDest = hasDestQ[headQ];
  assign rdReady    = validQ[rdTag] && doneQ[rdTag];
  assign headIdx    = headQ;
  assign tailIdx    = tailQ;
  assign strobe     = '{allocEn: allocFire, wbEn: wbAccept};

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      validQ   <= '0;
      doneQ    <= '0;
      hasDestQ <= '0;
      headQ    <= '0;
      tailQ    <= '0;
      countQ   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (retFire && headQ == TAG_W'(i)) begin
          validQ[i] <= 1'b0;
          doneQ[i]  <= 1'b0;
        end
        if (wbAccept && wbTag == TAG_W'(i)) doneQ[i] <= 1'b1;
        if (allocFire && tailQ == TAG_W'(i)) begin
          validQ[i]   <= 1'b1;
          doneQ[i]    <= 1'b0;
          hasDestQ[i] <= allocHasDest;
        end
      end
      if (allocFire) tailQ <= tailQ + 1'b1;
      if (retFire)   headQ <= headQ + 1'b1;
      countQ <= countQ + CNT_W'(allocFire) - CNT_W'(retFire);
    end
  end

  AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (allocFire) |=> (tailQ == $past(tailQ) + 1'b1)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (countQ <= CNT_W'(DEPTH))); // R3
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (full && !retFire && !flush) |=> full); // R3
  AST_WB_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !validQ[wbTag]) |=> !doneQ[$past(wbTag)]); // R5
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (retFire) |=> (headQ == $past(headQ) + 1'b1)); // R6
  AST_SLOT_FREED: assert property (@(posedge clk) disable iff (!rstN)
    (retFire) |=> !validQ[$past(headQ)]); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (flush) |=> (countQ == '0 && validQ == '0)); // R9
  AST_SWAP_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (allocFire && retFire) |=> $stable(countQ)); // R10
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int AREG_N = 8,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int AREG_W = $clog2(AREG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              allocReq,
  input  logic              allocHasDest,
  input  logic [AREG_W-1:0] allocDest,
  output logic              allocGrant,
  output logic [TAG_W-1:0]  allocTag,
  output logic              full,
  input  logic              wbValid,
  input  logic [TAG_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbData,
  input  logic [TAG_W-1:0]  rdTag,
  output logic              rdReady,
  output logic [DATA_W-1:0] rdData,
  output logic              retValid,
  output logic              retHasDest,
  output logic [AREG_W-1:0] retDest,
  output logic [DATA_W-1:0] retData
);
  robStrobe_t       strobe;
  logic [TAG_W-1:0] headIdx, tailIdx;

  rob_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .flush(flush),
    .allocReq(allocReq), .allocHasDest(allocHasDest),
    .wbValid(wbValid), .wbTag(wbTag), .rdTag(rdTag),
    .allocGrant(allocGrant), .allocTag(allocTag), .full(full),
    .rdReady(rdReady), .retValid(retValid), .retHasDest(retHasDest),
    .strobe(strobe), .headIdx(headIdx), .tailIdx(tailIdx)
  );

  rob_dpath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AREG_W(AREG_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .tailIdx(tailIdx), .headIdx(headIdx), .allocDest(allocDest),
    .wbTag(wbTag), .wbData(wbData), .rdTag(rdTag), .rdData(rdData),
    .retDest(retDest), .retData(retData)
  );
endmodule

// File: tb/reorder_buf_tb_top.sv
module reorder_buf_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN, flush, allocReq, allocHasDest, wbValid;
  logic [2:0]  allocDest, wbTag, rdTag, allocTag, retDest;
  logic [31:0] wbData, rdData, retData;
  logic        allocGrant, full, rdReady, retValid, retHasDest;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reorder_buf dut_i (
    .clk(clk), .rstN(rstN), .flush(flush),
    .allocReq(allocReq), .allocHasDest(allocHasDest), .allocDest(allocDest),
    .allocGrant(allocGrant), .allocTag(allocTag), .full(full),
    .wbValid(wbValid), .wbTag(wbTag), .wbData(wbData),
    .rdTag(rdTag), .rdReady(rdReady), .rdData(rdData),
    .retValid(retValid), .retHasDest(retHasDest),
    .retDest(retDest), .retData(retData)
  );

  typedef struct packed {
    logic        al;
    logic        hd;
    logic [2:0]  dst;
    logic        wb;
    logic [2:0]  wt;
    logic [15:0] wd;
    logic [2:0]  eTag;
    logic        eRv;
    logic        eHd;
    logic [2:0]  eDst;
    logic [15:0] eDat;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1, 1'b1, 3'd1, 1'b0, 3'd0, 16'h0000, 3'd0, 1'b0, 1'b0, 3'd0, 16'h0000},
    '{1'b1, 1'b1, 3'd2, 1'b0, 3'd0, 16'h0000, 3'd1, 1'b0, 1'b0, 3'd0, 16'h0000},
    '{1'b1, 1'b1, 3'd3, 1'b1, 3'd1, 16'h0022, 3'd2, 1'b0, 1'b0, 3'd0, 16'h0000},
    '{1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 16'h0033, 3'd3, 1'b0, 1'b0, 3'd0, 16'h0000},
    '{1'b0, 1'b0, 3'd0, 1'b1, 3'd0, 16'h0011, 3'd3, 1'b0, 1'b0, 3'd0, 16'h0000},
    '{1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd3, 1'b1, 1'b1, 3'd1, 16'h0011},
    '{1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd3, 1'b1, 1'b1, 3'd2, 16'h0022},
    '{1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd3, 1'b1, 1'b1, 3'd3, 16'h0033},
    '{1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd3, 1'b0, 1'b0, 3'd0, 16'h0000},
    '{1'b0, 1'b0, 3'd0, 1'b1, 3'd3, 16'h0044, 3'd4, 1'b0, 1'b0, 3'd0, 16'h0000},
    '{1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd4, 1'b1, 1'b0, 3'd0, 16'h0044},
    '{1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 16'h0000, 3'd4, 1'b0, 1'b0, 3'd0, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    allocReq = 0; allocHasDest = 0; allocDest = 0;
    wbValid = 0; wbTag = 0; wbData = 0; flush = 0;
  endtask

  // next falling edge, then settle
  task automatic nextCyc();
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 0; rdTag = 0; idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    chk("R1 full", {31'b0, full}, 0);
    chk("R1 retValid", {31'b0, retValid}, 0);
    chk("R1 allocTag", {29'b0, allocTag}, 0);
    chk("R1 rdReady", {31'b0, rdReady}, 0);

    // table walk: R2 tags, R6 order, R7 retire fields, R8 no-destination
    for (int i = 0; i < 12; i++) begin
      nextCyc();
      allocReq = VEC[i].al; allocHasDest = VEC[i].hd; allocDest = VEC[i].dst;
      wbValid = VEC[i].wb; wbTag = VEC[i].wt; wbData = {16'h0, VEC[i].wd};
      #1;
      chk("R2 allocTag", {29'b0, allocTag}, {29'b0, VEC[i].eTag});
      chk("R6 retValid", {31'b0, retValid}, {31'b0, VEC[i].eRv});
      if (VEC[i].eRv) begin
        chk("R7 retDest", {29'b0, retDest}, {29'b0, VEC[i].eDst});
        chk("R7 retData", retData, {16'h0, VEC[i].eDat});
        chk("R8 retHasDest", {31'b0, retHasDest}, {31'b0, VEC[i].eHd});
      end
    end

    // R9 flush with a retire pending
    nextCyc(); allocReq = 1; allocHasDest = 1; allocDest = 5;        // tag 4
    nextCyc(); allocReq = 1; wbValid = 1; wbTag = 4; wbData = 32'h99; // tag 5
    nextCyc(); #1;
    chk("R7 retValid before flush", {31'b0, retValid}, 1);
    nextCyc(); flush = 1; #1;
    chk("R9 retValid during flush", {31'b0, retValid}, 0);
    chk("R9 grant during flush", {31'b0, allocGrant}, 0);
    nextCyc(); rdTag = 4; #1;
    chk("R9 allocTag after flush", {29'b0, allocTag}, 0);
    chk("R9 retValid after flush", {31'b0, retValid}, 0);
    chk("R9 rdReady after flush", {31'b0, rdReady}, 0);

    // R5 write-back to an empty slot
    wbValid = 1; wbTag = 2; wbData = 32'h77;
    nextCyc(); rdTag = 2; #1;
    chk("R5 rdReady stray wb", {31'b0, rdReady}, 0);
    for (int k = 0; k < 3; k++) begin
      nextCyc(); allocReq = 1; allocHasDest = 1;
    end
    nextCyc(); #1;
    chk("R5 rdReady after alloc", {31'b0, rdReady}, 0);
    nextCyc(); flush = 1;

    // R3 fill to capacity
    for (int k = 0; k < 8; k++) begin
      nextCyc(); allocReq = 1; allocHasDest = 1; allocDest = 3'(k);
    end
    nextCyc(); allocReq = 1; #1;
    chk("R3 full", {31'b0, full}, 1);
    chk("R3 grant refused", {31'b0, allocGrant}, 0);
    nextCyc(); wbValid = 1; wbTag = 5; wbData = 32'h55; #1;
    chk("R3 still full", {31'b0, full}, 1);
    // R4 read port, R6 younger slot done
    nextCyc(); rdTag = 5; #1;
    chk("R4 rdReady", {31'b0, rdReady}, 1);
    chk("R4 rdData", rdData, 32'h55);
    chk("R6 no retire past head", {31'b0, retValid}, 0);
    rdTag = 4; #1;
    chk("R4 rdReady unfinished", {31'b0, rdReady}, 0);
    wbValid = 1; wbTag = 0; wbData = 32'h10;
    nextCyc(); allocReq = 1; #1;
    chk("R7 retValid", {31'b0, retValid}, 1);
    chk("R7 retDest", {29'b0, retDest}, 0);
    chk("R7 retData", retData, 32'h10);
    chk("R3 grant refused while full", {31'b0, allocGrant}, 0);
    nextCyc(); #1;
    chk("R3 not full after retire", {31'b0, full}, 0);
    chk("R7 one retire per cycle", {31'b0, retValid}, 0);
    wbValid = 1; wbTag = 1; wbData = 32'h20;
    // R10 alloc and retire together
    nextCyc(); allocReq = 1; allocHasDest = 1; #1;
    chk("R10 retValid", {31'b0, retValid}, 1);
    chk("R10 grant", {31'b0, allocGrant}, 1);
    chk("R10 allocTag", {29'b0, allocTag}, 0);
    nextCyc(); #1;
    chk("R10 occupancy kept", {31'b0, full}, 0);
    chk("R2 wrapped tag", {29'b0, allocTag}, 1);
    allocReq = 1;
    nextCyc(); #1;
    chk("R10 full after one more", {31'b0, full}, 1);

    nextCyc();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule